// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The controller gathers thirteen maskable request sources and one non-maskable input, and offers a processor one request at a time with a ready-made handler address. There are ten edge-triggered external lines, one timer line and two software request bits. Each source has its own enable bit and a 4-bit priority level, where a larger number means a more urgent request. A global threshold holds off any level below it. Hardware edges are latched as pending even while their source is disabled, so none is lost.

The processor sees a registered `irq_req` along with the source index, the level and a 32-bit vector. It answers with `cpu_ack` when it enters the handler and with `cpu_eoi` when the handler returns. Each acknowledge pushes the served level onto an in-service stack of up to 16 entries, and each end-of-interrupt pops one. While the stack holds a level, only a strictly more urgent request is offered. The vector is a base (boot or run) plus an offset. In per-level mode the offset is 0x200 plus the level times a programmable spacing; otherwise it is a fixed 0x180.

The sequencer has four states. `ST_IDLE` offers nothing. It moves to `ST_NMI_OFFER` when the non-maskable request is pending, or to `ST_OFFER` when an eligible request exists. `ST_OFFER` presents the winner and refreshes it every cycle. It returns to `ST_IDLE` on acknowledge, or when the winner disappears, and moves to `ST_NMI_OFFER` when a non-maskable request arrives. `ST_NMI_OFFER` moves to `ST_NMI_SVC` on acknowledge. `ST_NMI_SVC` returns to `ST_IDLE` on end-of-interrupt.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Source indices are: external line k is k (0..9), the timer is 10, and software bit j is 11+j. A rising edge on an external or timer line sets that source's pending bit, even while the source is disabled. Enable register (sel 0x0, bits [12:0], bit i = source i) gates delivery. A request held off by its enable bit is offered once the bit is set again.
- R2: Among eligible requests, the one with the largest level is offered. Levels are set by sel 0x8 (sources 0..7) and sel 0x9 (sources 8..12), 4 bits per source, with source i of a word at bits [4*(i mod 8)+3 : 4*(i mod 8)].
- R3: When eligible requests share the top level, the lowest source index is offered, and `irq_src` reports that index.
- R4: A maskable request is eligible only if its level is at least the threshold (sel 0x1, bits [3:0]). A request held off by the threshold is offered after the threshold is lowered.
- R5: While the in-service stack is non-empty, a maskable request is offered only if its level is strictly greater than the top entry. Equal or lower levels wait until end-of-interrupt.
- R6: A rising edge on `nmi_in` is offered regardless of enables and threshold, and it displaces any maskable offer, with `irq_nmi` high and vector offset 0x180. Acknowledging it leaves the stack untouched. No maskable request is offered until the next `cpu_eoi`.
- R7: Mode register (sel 0x2): bit 0 is per-level mode, bit 1 selects the boot base, and bits [17:8] set the spacing. With per-level mode set, a maskable vector offset is 0x200 + level*spacing; otherwise it is 0x180.
- R8: The vector equals the offset plus 0xBFC00000 when the boot bit is 1, or plus 0x80000000 when it is 0. The boot bit is 1 after reset.
- R9: Acknowledging an offered external or timer request clears its pending bit. A software request is the level of its register bit (sel 0x3, bits [1:0]) and stays active until software writes it to 0.
- R10: `cpu_ack` during an offer pushes the offered level, and `cpu_eoi` pops one entry. `svc_depth` shows the number of entries, from 0 to 16.
- R11: The offer is registered. A change made by a register write or by `cpu_eoi` appears on `irq_req` one clock edge after the edge that took the change.
- R12: After reset, `irq_req` is 0, `svc_depth` is 0, all enables are 0 and all levels are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_irq | input | NUM_EXT (10) | External request lines, edge sensitive |
| timer_irq | input | 1 | Timer request line, edge sensitive |
| nmi_in | input | 1 | Non-maskable request, edge sensitive |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cpu_ack | input | 1 | Processor takes the offered request |
| cpu_eoi | input | 1 | Processor ends the current handler |
| irq_req | output | 1 | Request offered to the processor |
| irq_nmi | output | 1 | Offered request is the non-maskable one |
| irq_src | output | IDX_W (4) | Offered source index |
| irq_level | output | LVL_W (4) | Offered priority level |
| irq_vector | output | 32 | Handler address |
| svc_depth | output | DEPTH_W (5) | In-service stack depth |

## Verification
The bench builds the block with its default parameters: ten external lines, 4-bit levels, a 10-bit spacing and a 16-entry stack. With these values every source can be swept against every one of the sixteen levels. Every pair of external lines can be raised together under equal, rising and falling level orders. The stack can also be driven through all sixteen nested levels up to full depth. The vector is checked against a formula computed in the bench for both bases, both modes and four spacings, including the all-ones spacing.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_OFFER     = 2'd1,
        ST_NMI_OFFER = 2'd2,
        ST_NMI_SVC   = 2'd3
    } ipc_state_e;

    localparam logic [3:0] SEL_ENABLE    = 4'h0;
    localparam logic [3:0] SEL_THRESH    = 4'h1;
    localparam logic [3:0] SEL_MODE      = 4'h2;
    localparam logic [3:0] SEL_SOFT      = 4'h3;
    localparam logic [3:0] SEL_PRIO_BASE = 4'h8;

    localparam logic [31:0] BASE_BOOT   = 32'hBFC0_0000;
    localparam logic [31:0] BASE_RUN    = 32'h8000_0000;
    localparam logic [31:0] OFS_GENERAL = 32'h0000_0180;
    localparam logic [31:0] OFS_LEVEL   = 32'h0000_0200;

endpackage

// File: rtl/ipc_pending.sv
module ipc_pending #(
    parameter int NUM_HW = 11,
    parameter int NUM_SW = 2,
    parameter int IDX_W  = $clog2(NUM_HW + NUM_SW)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_HW-1:0]          hw_req,
    input  logic [NUM_SW-1:0]          sw_bits,
    input  logic                       clr_valid,
    input  logic [IDX_W-1:0]           clr_idx,
    output logic [NUM_HW+NUM_SW-1:0]   pend
);

    // Edge-latched hardware lines; set beats clear in the same cycle.
    for (genvar g = 0; g < NUM_HW; g++) begin : g_hw
        logic prev_q;
        logic pend_q;
        logic rise;
        logic clr_hit;

        assign rise    = hw_req[g] & ~prev_q;
        assign clr_hit = clr_valid && (clr_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                pend_q <= 1'b0;
            end else begin
                prev_q <= hw_req[g];
                if (rise)
                    pend_q <= 1'b1;
                else if (clr_hit)
                    pend_q <= 1'b0;
            end
        end

        assign pend[g] = pend_q;
    end

    // Software requests are level-held by their register bits.
    for (genvar j = 0; j < NUM_SW; j++) begin : g_sw
        assign pend[NUM_HW + j] = sw_bits[j];
    end

endmodule

// File: rtl/ipc_arbiter.sv
module ipc_arbiter #(
    parameter int NSRC  = 13,
    parameter int LVL_W = 4,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]        pend,
    input  logic [NSRC-1:0]        en,
    input  logic [NSRC*LVL_W-1:0]  prio_flat,
    input  logic [LVL_W-1:0]       thresh,
    input  logic                   svc_busy,
    input  logic [LVL_W-1:0]       svc_level,
    output logic                   win_valid,
    output logic [IDX_W-1:0]       win_idx,
    output logic [LVL_W-1:0]       win_level
);

    logic [NSRC-1:0] elig;

    for (genvar g = 0; g < NSRC; g++) begin : g_elig
        logic [LVL_W-1:0] lvl;
        assign lvl     = prio_flat[g*LVL_W +: LVL_W];
        assign elig[g] = pend[g] && en[g] && (lvl >= thresh) &&
                         (!svc_busy || (lvl > svc_level));
    end

    // Ascending scan: strictly-greater replacement keeps the lowest index on ties.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_level = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (!win_valid || (prio_flat[i*LVL_W +: LVL_W] > win_level))) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_level = prio_flat[i*LVL_W +: LVL_W];
            end
        end
    end

endmodule

// File: rtl/ipc_lvl_stack.sv
module ipc_lvl_stack #(
    parameter int DEPTH   = 16,
    parameter int LVL_W   = 4,
    parameter int DEPTH_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [LVL_W-1:0]   push_level,
    input  logic               pop,
    output logic               busy,
    output logic [LVL_W-1:0]   top_level,
    output logic [DEPTH_W-1:0] depth
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [LVL_W-1:0]   mem_q [DEPTH];
    logic [DEPTH_W-1:0] depth_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth_q <= '0;
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= '0;
        end else begin
            if (push && pop && (depth_q != '0)) begin
                mem_q[PTR_W'(depth_q - 1'b1)] <= push_level;
            end else if (push) begin
                mem_q[depth_q[PTR_W-1:0]] <= push_level;
                depth_q <= depth_q + 1'b1;
            end else if (pop && (depth_q != '0)) begin
                depth_q <= depth_q - 1'b1;
            end
        end
    end

    assign busy      = (depth_q != '0);
    assign top_level = busy ? mem_q[PTR_W'(depth_q - 1'b1)] : '0;
    assign depth     = depth_q;

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (depth_q != DEPTH_W'(DEPTH)));

endmodule

// File: rtl/ipc_vector.sv
module ipc_vector #(
    parameter int LVL_W   = 4,
    parameter int SPACE_W = 10
) (
    input  logic               is_nmi,
    input  logic [LVL_W-1:0]   level,
    input  logic               per_level,
    input  logic               boot,
    input  logic [SPACE_W-1:0] spacing,
    output logic [31:0]        addr
);

    import ipc_pkg::*;

    logic [31:0] ofs;
    logic [31:0] base;

    always_comb begin
        if (per_level && !is_nmi)
            ofs = OFS_LEVEL + (32'(level) * 32'(spacing));
        else
            ofs = OFS_GENERAL;
        base = boot ? BASE_BOOT : BASE_RUN;
        addr = base + ofs;
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int NUM_EXT   = 10,
    parameter int LVL_W     = 4,
    parameter int SPACE_W   = 10,
    parameter int STK_DEPTH = 16,
    parameter int IDX_W     = $clog2(NUM_EXT + 3),
    parameter int DEPTH_W   = $clog2(STK_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] ext_irq,
    input  logic               timer_irq,
    input  logic               nmi_in,
    input  logic               cfg_we,
    input  logic [3:0]         cfg_sel,
    input  logic [31:0]        cfg_wdata,
    input  logic               cpu_ack,
    input  logic               cpu_eoi,
    output logic               irq_req,
    output logic               irq_nmi,
    output logic [IDX_W-1:0]   irq_src,
    output logic [LVL_W-1:0]   irq_level,
    output logic [31:0]        irq_vector,
    output logic [DEPTH_W-1:0] svc_depth
);

    import ipc_pkg::*;

    localparam int NUM_HW   = NUM_EXT + 1;
    localparam int NUM_SW   = 2;
    localparam int NSRC     = NUM_HW + NUM_SW;
    localparam int PER_WORD = 32 / LVL_W;

    // ---------------- configuration registers ----------------
    logic [NSRC-1:0]       en_q;
    logic [NSRC*LVL_W-1:0] prio_q;
    logic [LVL_W-1:0]      thresh_q;
    logic                  per_level_q;
    logic                  boot_q;
    logic [SPACE_W-1:0]    spacing_q;
    logic [NUM_SW-1:0]     sw_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q        <= '0;
            thresh_q    <= '0;
            per_level_q <= 1'b0;
            boot_q      <= 1'b1;
            spacing_q   <= '0;
            sw_q        <= '0;
        end else if (cfg_we) begin
            unique case (cfg_sel)
                SEL_ENABLE: en_q <= cfg_wdata[NSRC-1:0];
                SEL_THRESH: thresh_q <= cfg_wdata[LVL_W-1:0];
                SEL_MODE: begin
                    per_level_q <= cfg_wdata[0];
                    boot_q      <= cfg_wdata[1];
                    spacing_q   <= cfg_wdata[8 +: SPACE_W];
                end
                SEL_SOFT: sw_q <= cfg_wdata[NUM_SW-1:0];
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_prio
        localparam int WORD = g / PER_WORD;
        localparam int SLOT = g % PER_WORD;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                prio_q[g*LVL_W +: LVL_W] <= '0;
            else if (cfg_we && (cfg_sel == 4'(int'(SEL_PRIO_BASE) + WORD)))
                prio_q[g*LVL_W +: LVL_W] <= cfg_wdata[SLOT*LVL_W +: LVL_W];
        end
    end

    // ---------------- sequencer state ----------------
    ipc_state_e         state_q, state_d;
    logic [IDX_W-1:0]   src_q;
    logic [LVL_W-1:0]   lvl_q;
    logic [31:0]        vec_q;
    logic               nmi_q;
    logic               nmi_prev_q, nmi_pend_q;

    logic [NSRC-1:0]    pend;
    logic               win_valid;
    logic [IDX_W-1:0]   win_idx;
    logic [LVL_W-1:0]   win_level;
    logic               svc_busy;
    logic [LVL_W-1:0]   svc_top;
    logic [31:0]        vec_next;
    logic               take_mask;
    logic               take_nmi;
    logic               pop_req;

    assign take_mask = cpu_ack && (state_q == ST_OFFER);
    assign take_nmi  = cpu_ack && (state_q == ST_NMI_OFFER);
    assign pop_req   = cpu_eoi && (state_q != ST_NMI_SVC);

    ipc_pending #(
        .NUM_HW (NUM_HW),
        .NUM_SW (NUM_SW),
        .IDX_W  (IDX_W)
    ) u_pending (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_req    ({timer_irq, ext_irq}),
        .sw_bits   (sw_q),
        .clr_valid (take_mask),
        .clr_idx   (src_q),
        .pend      (pend)
    );

    ipc_lvl_stack #(
        .DEPTH   (STK_DEPTH),
        .LVL_W   (LVL_W),
        .DEPTH_W (DEPTH_W)
    ) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (take_mask),
        .push_level (lvl_q),
        .pop        (pop_req),
        .busy       (svc_busy),
        .top_level  (svc_top),
        .depth      (svc_depth)
    );

    ipc_arbiter #(
        .NSRC  (NSRC),
        .LVL_W (LVL_W),
        .IDX_W (IDX_W)
    ) u_arb (
        .pend      (pend),
        .en        (en_q),
        .prio_flat (prio_q),
        .thresh    (thresh_q),
        .svc_busy  (svc_busy),
        .svc_level (svc_top),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_level (win_level)
    );

    ipc_vector #(
        .LVL_W   (LVL_W),
        .SPACE_W (SPACE_W)
    ) u_vec (
        .is_nmi    (state_d == ST_NMI_OFFER),
        .level     (win_level),
        .per_level (per_level_q),
        .boot      (boot_q),
        .spacing   (spacing_q),
        .addr      (vec_next)
    );

    // Non-maskable edge latch; a new edge wins over the clearing acknowledge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_prev_q <= 1'b0;
            nmi_pend_q <= 1'b0;
        end else begin
            nmi_prev_q <= nmi_in;
            if (nmi_in && !nmi_prev_q)
                nmi_pend_q <= 1'b1;
            else if (take_nmi)
                nmi_pend_q <= 1'b0;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (nmi_pend_q)
                    state_d = ST_NMI_OFFER;
                else if (win_valid)
                    state_d = ST_OFFER;
            end
            ST_OFFER: begin
                if (cpu_ack)
                    state_d = ST_IDLE;
                else if (nmi_pend_q)
                    state_d = ST_NMI_OFFER;
                else if (!win_valid)
                    state_d = ST_IDLE;
            end
            ST_NMI_OFFER: begin
                if (cpu_ack)
                    state_d = ST_NMI_SVC;
            end
            ST_NMI_SVC: begin
                if (cpu_eoi)
                    state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Registered offer contents
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            lvl_q <= '0;
            vec_q <= '0;
            nmi_q <= 1'b0;
        end else begin
            unique case (state_d)
                ST_OFFER: begin
                    src_q <= win_idx;
                    lvl_q <= win_level;
                    vec_q <= vec_next;
                    nmi_q <= 1'b0;
                end
                ST_NMI_OFFER: begin
                    src_q <= '0;
                    lvl_q <= '0;
                    vec_q <= vec_next;
                    nmi_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign irq_req    = (state_q == ST_OFFER) || (state_q == ST_NMI_OFFER);
    assign irq_nmi    = nmi_q;
    assign irq_src    = src_q;
    assign irq_level  = lvl_q;
    assign irq_vector = vec_q;

    // R4
    thresh_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_level >= thresh_q));

    // R5
    nest_strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && svc_busy) |-> (win_level > svc_top));

    // R6
    nmi_takeover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend_q && ((state_q == ST_IDLE) || ((state_q == ST_OFFER) && !cpu_ack)))
        |=> (irq_req && irq_nmi));

    // R10
    ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_mask && !cpu_eoi) |=> (svc_depth == DEPTH_W'($past(svc_depth) + 1'b1)));

endmodule

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  ext_irq = '0;
    logic        timer_irq = 1'b0;
    logic        nmi_in = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cpu_ack = 1'b0;
    logic        cpu_eoi = 1'b0;
    logic        irq_req, irq_nmi;
    logic [3:0]  irq_src, irq_level;
    logic [31:0] irq_vector;
    logic [4:0]  svc_depth;

    int n_chk = 0;
    int n_bad = 0;
    logic [3:0]  prio_sh [13];
    logic [1:0]  sw_sh = '0;

    always #10 clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .timer_irq(timer_irq),
        .nmi_in(nmi_in), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cpu_ack(cpu_ack), .cpu_eoi(cpu_eoi), .irq_req(irq_req), .irq_nmi(irq_nmi),
        .irq_src(irq_src), .irq_level(irq_level), .irq_vector(irq_vector),
        .svc_depth(svc_depth)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [3:0] sel, input logic [31:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic set_prio(input int s, input logic [3:0] p);
        logic [31:0] w;
        int word;
        prio_sh[s] = p;
        word = s / 8;
        w = '0;
        for (int k = 0; k < 8; k++)
            if (word*8 + k < 13) w[k*4 +: 4] = prio_sh[word*8 + k];
        cfg(4'(8 + word), w);
    endtask

    task automatic set_mode(input logic per, input logic boot, input logic [9:0] sp);
        cfg(4'h2, {14'd0, sp, 6'd0, boot, per});
    endtask

    // one clock edge; external/timer pulse or software bit set
    task automatic fire(input int s);
        if (s < 10) begin
            ext_irq[s] = 1'b1; tick(1); ext_irq[s] = 1'b0;
        end else if (s == 10) begin
            timer_irq = 1'b1; tick(1); timer_irq = 1'b0;
        end else begin
            sw_sh[s-11] = 1'b1; cfg(4'h3, {30'd0, sw_sh});
        end
    endtask

    task automatic ack();
        cpu_ack = 1'b1; tick(1); cpu_ack = 1'b0;
    endtask

    task automatic eoi();
        cpu_eoi = 1'b1; tick(1); cpu_eoi = 1'b0;
    endtask

    function automatic logic [31:0] vexp(input logic boot, input logic per,
                                         input int lvl, input int sp);
        logic [31:0] b;
        b = boot ? 32'hBFC0_0000 : 32'h8000_0000;
        return per ? b + 32'h200 + 32'(lvl * sp) : b + 32'h180;
    endfunction

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        int sps [4];
        sps = '{0, 32'h20, 32'h80, 32'h3FF};
        for (int i = 0; i < 13; i++) prio_sh[i] = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R12: reset state, masks all disabled
        chk("R12 irq_req after reset", 32'(irq_req), 0);
        chk("R12 depth after reset", 32'(svc_depth), 0);
        fire(0); tick(2);
        chk("R12 source 0 disabled at reset", 32'(irq_req), 0);
        cfg(4'h0, 32'h1FFF); tick(1);
        chk("R1 remembered request after enable", 32'(irq_req), 1);
        chk("R8 boot base after reset", irq_vector, 32'hBFC0_0180);
        ack(); eoi();

        // R2/R7 sweep: every source at every level
        set_mode(1'b1, 1'b0, 10'h20);
        for (int s = 0; s < 13; s++) begin
            for (int l = 0; l < 16; l++) begin
                set_prio(s, 4'(l));
                fire(s); tick(1);
                chk("R2 request offered", 32'(irq_req), 1);
                chk("R3 source index", 32'(irq_src), 32'(s));
                chk("R2 level", 32'(irq_level), 32'(l));
                chk("R7 per-level vector", irq_vector, vexp(1'b0, 1'b1, l, 32'h20));
                ack(); tick(1);
                chk("R5 equal level held off", 32'(irq_req), 0);
                chk("R10 depth after ack", 32'(svc_depth), 1);
                eoi();
                chk("R10 depth after eoi", 32'(svc_depth), 0);
                tick(1);
                if (s >= 11) begin
                    chk("R9 software bit persists", 32'(irq_req), 1);
                    sw_sh[s-11] = 1'b0; cfg(4'h3, {30'd0, sw_sh}); tick(1);
                    chk("R9 software bit cleared by write", 32'(irq_req), 0);
                end else begin
                    chk("R9 pending cleared by ack", 32'(irq_req), 0);
                end
            end
        end

        // R2/R3 pairs of external lines
        for (int a = 0; a < 10; a++) begin
            for (int b = a + 1; b < 10; b++) begin
                for (int c = 0; c < 3; c++) begin
                    int pa, pb, w, lo;
                    pa = (c == 0) ? 4 : (c == 1) ? 2 : 11;
                    pb = (c == 0) ? 4 : (c == 1) ? 11 : 2;
                    set_prio(a, 4'(pa)); set_prio(b, 4'(pb));
                    ext_irq[a] = 1'b1; ext_irq[b] = 1'b1; tick(1);
                    ext_irq = '0; tick(1);
                    w  = (pb > pa) ? b : a;
                    lo = (w == a) ? b : a;
                    if (c == 0) chk("R3 tie goes to lowest index", 32'(irq_src), 32'(w));
                    else        chk("R2 higher level wins", 32'(irq_src), 32'(w));
                    ack(); tick(1);
                    chk("R5 lower level waits", 32'(irq_req), 0);
                    eoi(); tick(1);
                    chk("R5 waiting request after eoi", 32'(irq_src), 32'(lo));
                    chk("R5 waiting request offered", 32'(irq_req), 1);
                    ack(); eoi();
                end
            end
        end

        // R4 threshold sweep, source 0 at level 7
        set_prio(0, 4'd7);
        for (int t = 0; t < 16; t++) begin
            cfg(4'h1, 32'(t));
            fire(0); tick(1);
            chk("R4 threshold gate", 32'(irq_req), (7 >= t) ? 1 : 0);
            if (7 < t) begin
                cfg(4'h1, 0);
                chk("R11 no change before next edge", 32'(irq_req), 0);
                tick(1);
                chk("R4 held request after lowering", 32'(irq_req), 1);
            end
            ack(); eoi();
        end
        cfg(4'h1, 0);

        // R1/R11 per-line masking of hardware sources
        for (int s = 0; s < 11; s++) begin
            cfg(4'h0, 32'h1FFF & ~(32'd1 << s));
            fire(s); tick(2);
            chk("R1 disabled source not offered", 32'(irq_req), 0);
            cfg(4'h0, 32'h1FFF);
            chk("R11 offer one edge after write", 32'(irq_req), 0);
            tick(1);
            chk("R1 remembered request delivered", 32'(irq_req), 1);
            chk("R1 remembered source", 32'(irq_src), 32'(s));
            ack(); eoi();
        end

        // R5/R10 nesting ladder to full depth
        for (int l = 0; l < 16; l++) begin
            set_prio(0, 4'(l));
            fire(0); tick(1);
            chk("R5 higher level preempts", 32'(irq_req), 1);
            ack();
            chk("R10 depth grows", 32'(svc_depth), 32'(l + 1));
        end
        fire(0); tick(2);
        chk("R5 equal to top held", 32'(irq_req), 0);
        for (int k = 16; k > 0; k--) begin
            eoi();
            chk("R10 depth shrinks", 32'(svc_depth), 32'(k - 1));
        end
        chk("R11 offer after final eoi", 32'(irq_req), 1);
        ack(); eoi();
        chk("R10 stack empty", 32'(svc_depth), 0);

        // R6 non-maskable path
        set_mode(1'b1, 1'b1, 10'h40);
        cfg(4'h0, 0); cfg(4'h1, 32'hF);
        nmi_in = 1'b1; tick(1); nmi_in = 1'b0; tick(1);
        chk("R6 nmi offered despite masks", 32'(irq_req), 1);
        chk("R6 nmi flag", 32'(irq_nmi), 1);
        chk("R8 nmi vector boot base", irq_vector, 32'hBFC0_0180);
        cfg(4'h0, 32'h1FFF); cfg(4'h1, 0);
        set_prio(2, 4'd9); fire(2); tick(2);
        chk("R6 nmi keeps precedence", 32'(irq_nmi), 1);
        ack(); tick(1);
        chk("R6 maskable blocked during nmi handler", 32'(irq_req), 0);
        chk("R6 stack untouched", 32'(svc_depth), 0);
        eoi(); tick(1);
        chk("R6 maskable after nmi eoi", 32'(irq_src), 2);
        chk("R7 vector boot per-level", irq_vector, vexp(1'b1, 1'b1, 9, 32'h40));
        ack(); eoi();
        set_prio(3, 4'd5); fire(3); tick(1);
        chk("R6 maskable offered first", 32'(irq_src), 3);
        nmi_in = 1'b1; tick(1); nmi_in = 1'b0; tick(1);
        chk("R6 nmi displaces offer", 32'(irq_nmi), 1);
        ack(); eoi(); tick(1);
        chk("R6 displaced request returns", 32'(irq_src), 3);
        ack(); eoi();

        // R7/R8 vector sweep
        for (int bt = 0; bt < 2; bt++) begin
            for (int pm = 0; pm < 2; pm++) begin
                for (int si = 0; si < 4; si++) begin
                    set_mode(1'(pm), 1'(bt), 10'(sps[si]));
                    for (int l = 0; l < 16; l++) begin
                        set_prio(1, 4'(l));
                        fire(1); tick(1);
                        chk("R7 R8 vector", irq_vector, vexp(1'(bt), 1'(pm), l, sps[si]));
                        ack(); eoi();
                    end
                end
            end
        end

        summary();
        $finish;
    end

endmodule